// File: doc/BRIEF.md
# Soft-Start Ramp and Overcurrent Retry Sequencer

This block sequences the start-up of a voltage-mode buck controller. It runs on the switching-frequency clock, so every cycle of it is one switching period. Once the supply-good flag and the enable are both high, it drives a digital reference code that rises by one step per cycle from zero to full scale. A converter built around it therefore produces output pulses that widen gradually. After the ramp it holds the code at full scale and reports that the output is regulating.

An overcurrent flag, sampled once per switching cycle while the power stage is active, shuts switching off at once and starts a retry sequence. The sequencer then spends a fixed number of silent ramp periods with switching inhibited and the code at zero. After that it begins a fresh ramp. While the sequencer waits, it ignores any further overcurrent flags. A new trip during the retry ramp, or later during regulation, starts another full wait, and this repeats with no limit. If the supply-good flag or the enable drops, every phase is abandoned and the block returns to the off state.

The states are named OFF (status 00), RAMP (status 01), RUN (status 10) and HICCUP (status 11). The transitions are:
- OFF→RAMP when the block is enabled.
- RAMP→RUN at full scale.
- RAMP→HICCUP and RUN→HICCUP on an overcurrent flag.
- HICCUP→HICCUP at the end of each silent period except the last.
- HICCUP→RAMP after the last silent period.
- Any state→OFF when it is disabled.

Top module: `softstart_hiccup_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, status is 00 (OFF), ref_code is 0 and pwm_inhibit is 1.
- R2: If pwr_good or enable is low at a clock edge, then from any state the next cycle shows status 00, ref_code 0 and pwm_inhibit 1.
- R3: From OFF with pwr_good and enable both high at an edge, the next cycle shows status 01 (RAMP), ref_code 0 and pwm_inhibit 0. In RAMP, ref_code then rises by exactly one per cycle.
- R4: A ramp lasts exactly 2^CODE_W cycles (ref_code 0 to all ones). The following cycle shows status 10 (RUN).
- R5: If oc_flag is high at an edge in RAMP or RUN, and the block stays enabled, the next cycle shows status 11 (HICCUP), pwm_inhibit 1 and ref_code 0.
- R6: HICCUP lasts exactly PERIODS×2^CODE_W cycles with pwm_inhibit 1 and ref_code 0. It is followed by RAMP with ref_code 0.
- R7: While in HICCUP, oc_flag is ignored, so the wait length is unchanged by any oc_flag pattern.
- R8: An oc_flag during a retry ramp starts a new full-length HICCUP, and this repeats without limit.
- R9: In RUN without overcurrent, ref_code stays at all ones and pwm_inhibit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-frequency clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Bias supply above its power-on threshold |
| enable | input | 1 | Qualified enable |
| oc_flag | input | 1 | Per-cycle overcurrent comparator result |
| ref_code | output | CODE_W | Reference code for the DAC |
| pwm_inhibit | output | 1 | High forces switching off |
| status | output | 2 | 00 off, 01 ramp, 10 run, 11 hiccup |

## Verification
The bench builds the block with CODE_W = 4 and PERIODS = 3. This gives a 16-cycle ramp and a 48-cycle retry wait instead of 2048 and 6144 cycles. With these values, full ramps, complete retry waits, back-to-back retries and aborts in every state all fit in a few thousand cycles of random and directed stimulus. The default values differ only in counter width and retry period count, so the same transitions are exercised.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_OFF    = 2'b00,
        SEQ_RAMP   = 2'b01,
        SEQ_RUN    = 2'b10,
        SEQ_HICCUP = 2'b11
    } seq_state_e;
endpackage

// File: rtl/ss_ramp_counter.sv
module ss_ramp_counter #(
    parameter int CODE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [CODE_W-1:0] cnt,
    output logic              at_max
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign at_max = &cnt;
endmodule

// File: rtl/ss_retry_counter.sv
module ss_retry_counter #(
    parameter int PERIODS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int RW = (PERIODS > 1) ? $clog2(PERIODS) : 1;
    localparam logic [RW-1:0] LAST_VAL = RW'(PERIODS - 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
    import ss_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_ok,
    input  logic       oc_flag,
    input  logic       ramp_max,
    input  logic       retry_last,
    output seq_state_e state,
    output logic       cnt_clr,
    output logic       cnt_inc,
    output logic       retry_clr,
    output logic       retry_inc
);
    seq_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEQ_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!run_ok) begin
            nxt = SEQ_OFF;
        end else begin
            unique case (state)
                SEQ_OFF:    nxt = SEQ_RAMP;
                SEQ_RAMP: begin
                    if (oc_flag)
                        nxt = SEQ_HICCUP;
                    else if (ramp_max)
                        nxt = SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (oc_flag)
                        nxt = SEQ_HICCUP;
                end
                SEQ_HICCUP: begin
                    if (ramp_max && retry_last)
                        nxt = SEQ_RAMP;
                end
            endcase
        end
    end

    always_comb begin
        cnt_clr   = (nxt != state);
        cnt_inc   = !cnt_clr && ((state == SEQ_RAMP) || (state == SEQ_HICCUP));
        retry_clr = (nxt != SEQ_HICCUP);
        retry_inc = (state == SEQ_HICCUP) && (nxt == SEQ_HICCUP) && ramp_max;
    end
endmodule

// File: rtl/softstart_hiccup_seq.sv
module softstart_hiccup_seq
    import ss_seq_pkg::*;
#(
    parameter int CODE_W  = 11,
    parameter int PERIODS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              enable,
    input  logic              oc_flag,
    output logic [CODE_W-1:0] ref_code,
    output logic              pwm_inhibit,
    output logic [1:0]        status
);
    seq_state_e        state;
    logic [CODE_W-1:0] cnt;
    logic              at_max, retry_last;
    logic              cnt_clr, cnt_inc, retry_clr, retry_inc;

    ss_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_ok     (pwr_good && enable),
        .oc_flag    (oc_flag),
        .ramp_max   (at_max),
        .retry_last (retry_last),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .retry_clr  (retry_clr),
        .retry_inc  (retry_inc)
    );

    ss_ramp_counter #(.CODE_W(CODE_W)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .cnt    (cnt),
        .at_max (at_max)
    );

    ss_retry_counter #(.PERIODS(PERIODS)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (retry_clr),
        .inc   (retry_inc),
        .last  (retry_last)
    );

    always_comb begin
        status = state;
        unique case (state)
            SEQ_OFF: begin
                ref_code    = '0;
                pwm_inhibit = 1'b1;
            end
            SEQ_RAMP: begin
                ref_code    = cnt;
                pwm_inhibit = 1'b0;
            end
            SEQ_RUN: begin
                ref_code    = '1;
                pwm_inhibit = 1'b0;
            end
            SEQ_HICCUP: begin
                ref_code    = '0;
                pwm_inhibit = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ss_seq_checker.sv
module ss_seq_checker
    import ss_seq_pkg::*;
#(
    parameter int CODE_W  = 11,
    parameter int PERIODS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_good,
    input logic              enable,
    input logic              oc_flag,
    input logic [CODE_W-1:0] ref_code,
    input logic              pwm_inhibit,
    input logic [1:0]        status
);
    localparam int RAMP_CYC = 1 << CODE_W;
    localparam int HIC_CYC  = PERIODS * RAMP_CYC;

    int ramp_len;
    int hic_len;
    logic on;

    assign on = pwr_good && enable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_len <= 0;
            hic_len  <= 0;
        end else begin
            ramp_len <= (status == SEQ_RAMP)   ? ramp_len + 1 : 0;
            hic_len  <= (status == SEQ_HICCUP) ? hic_len + 1  : 0;
        end
    end

    a_r2_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (status == SEQ_OFF) && pwm_inhibit && (ref_code == '0));

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (status == SEQ_OFF) && on |=> (status == SEQ_RAMP) && (ref_code == '0) && !pwm_inhibit);

    a_r3_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (status == SEQ_RAMP) && !(&ref_code) && on && !oc_flag
        |=> (status == SEQ_RAMP) && (ref_code == CODE_W'($past(ref_code) + 1'b1)));

    a_r4_ramp_len: assert property (@(posedge clk) disable iff (!rst_n)
        (status == SEQ_RUN) && ($past(status) == SEQ_RAMP) |-> (ramp_len == RAMP_CYC));

    a_r5_oc_trip: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == SEQ_RAMP) || (status == SEQ_RUN)) && oc_flag && on
        |=> (status == SEQ_HICCUP) && pwm_inhibit);

    a_r6_hiccup_len: assert property (@(posedge clk) disable iff (!rst_n)
        (status == SEQ_RAMP) && ($past(status) == SEQ_HICCUP) |-> (hic_len == HIC_CYC) && (ref_code == '0));

    a_r6_hiccup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (status == SEQ_HICCUP) |-> pwm_inhibit && (ref_code == '0));

    a_r7_oc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (status == SEQ_HICCUP) && oc_flag && on && (hic_len < HIC_CYC - 1) |=> (status == SEQ_HICCUP));

    a_r9_run_full: assert property (@(posedge clk) disable iff (!rst_n)
        (status == SEQ_RUN) |-> (&ref_code) && !pwm_inhibit);
endmodule

bind softstart_hiccup_seq ss_seq_checker #(.CODE_W(CODE_W), .PERIODS(PERIODS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .enable      (enable),
    .oc_flag     (oc_flag),
    .ref_code    (ref_code),
    .pwm_inhibit (pwm_inhibit),
    .status      (status)
);

// File: tb/sim_softstart_hiccup_seq.sv
module sim_softstart_hiccup_seq;
    localparam int CODE_W  = 4;
    localparam int PERIODS = 3;
    localparam int RAMP_CYC = 1 << CODE_W;
    localparam int HIC_CYC  = PERIODS * RAMP_CYC;
    localparam logic [CODE_W-1:0] FULL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, enable = 1'b0, oc_flag = 1'b0;
    logic [CODE_W-1:0] ref_code;
    logic pwm_inhibit;
    logic [1:0] status;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    softstart_hiccup_seq #(.CODE_W(CODE_W), .PERIODS(PERIODS)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .enable(enable),
        .oc_flag(oc_flag), .ref_code(ref_code), .pwm_inhibit(pwm_inhibit), .status(status)
    );

    // Reference model written from the requirements: 0 off, 1 ramp, 2 run, 3 hiccup
    int m_st = 0, m_cnt = 0, m_per = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_per = 0;
        end else if (!(pwr_good && enable)) begin
            m_st = 0; m_cnt = 0; m_per = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_cnt = 0; end
                1: begin
                    if (oc_flag) begin m_st = 3; m_cnt = 0; m_per = 0; end
                    else if (m_cnt == RAMP_CYC - 1) m_st = 2;
                    else m_cnt++;
                end
                2: if (oc_flag) begin m_st = 3; m_cnt = 0; m_per = 0; end
                default: begin
                    if (m_cnt == RAMP_CYC - 1) begin
                        m_cnt = 0;
                        if (m_per == PERIODS - 1) begin m_st = 1; m_per = 0; end
                        else m_per++;
                    end else m_cnt++;
                end
            endcase
        end
    end

    function automatic int exp_ref(int st, int c);
        if (st == 1) return c;
        if (st == 2) return int'(FULL);
        return 0;
    endfunction

    function automatic bit exp_inh(int st);
        return (st == 0) || (st == 3);
    endfunction

    function automatic string st_tag(int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_model();
        int act, exp;
        act = {int'(status), int'(ref_code), int'(pwm_inhibit)};
        exp = (m_st << (CODE_W + 1)) | (exp_ref(m_st, m_cnt) << 1) | int'(exp_inh(m_st));
        act = (int'(status) << (CODE_W + 1)) | (int'(ref_code) << 1) | int'(pwm_inhibit);
        chk(act == exp, st_tag(m_st), "packed status/ref/inhibit", act, exp);
    endtask

    task automatic tick(bit pg, bit en, bit oc);
        pwr_good = pg; enable = en; oc_flag = oc;
        @(negedge clk);
        cmp_model();
    endtask

    task automatic measure_hiccup(string tag);
        int n;
        n = 1;
        for (int i = 0; i < 400; i++) begin
            tick(1'b1, 1'b1, 1'($urandom % 2));
            if (status == 2'b11) n++;
            else break;
        end
        chk(n == HIC_CYC, tag, "hiccup length", n, HIC_CYC);
        chk(status == 2'b01 && ref_code == 0, tag, "ramp after hiccup", int'(status), 1);
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        @(negedge clk);
        chk(status == 2'b00 && ref_code == 0 && pwm_inhibit, "R1", "status in reset", int'(status), 0);
        tick(1'b1, 1'b1, 1'b0);
        chk(status == 2'b00 && pwm_inhibit, "R1", "held off during reset", int'(status), 0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 1'b0);
        chk(status == 2'b00 && ref_code == 0 && pwm_inhibit, "R1", "first cycle after reset", int'(status), 0);

        // R3/R4: start and ramp length
        tick(1'b1, 1'b1, 1'b0);
        chk(status == 2'b01 && ref_code == 0 && !pwm_inhibit, "R3", "ramp start", int'(status), 1);
        n = 1;
        for (int i = 0; i < 100; i++) begin
            tick(1'b1, 1'b1, 1'b0);
            if (status == 2'b01) n++;
            else break;
        end
        chk(n == RAMP_CYC, "R4", "ramp length", n, RAMP_CYC);
        chk(status == 2'b10, "R4", "run after ramp", int'(status), 2);
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b1, 1'b0);
        chk(ref_code == FULL && !pwm_inhibit, "R9", "run saturated", int'(ref_code), int'(FULL));

        // R5/R6/R7: trip from run, wait with random oc_flag
        tick(1'b1, 1'b1, 1'b1);
        chk(status == 2'b11 && pwm_inhibit && ref_code == 0, "R5", "trip from run", int'(status), 3);
        measure_hiccup("R7");

        // R8: repeated trips during retry ramps
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b0);
            tick(1'b1, 1'b1, 1'b1);
            chk(status == 2'b11, "R8", "retrip in retry ramp", int'(status), 3);
            measure_hiccup("R8");
        end

        // R2: aborts from each active state
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        chk(status == 2'b00 && pwm_inhibit && ref_code == 0, "R2", "abort from ramp", int'(status), 0);
        for (int i = 0; i < 30; i++) tick(1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
        chk(status == 2'b00 && ref_code == 0, "R2", "abort from run", int'(status), 0);
        tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b1);
        chk(status == 2'b00 && pwm_inhibit, "R2", "abort from hiccup", int'(status), 0);

        // Random phase against the model
        for (int i = 0; i < 5000; i++) begin
            bit pg, en, oc;
            pg = ($urandom % 200) != 0;
            en = ($urandom % 150) != 0;
            oc = ($urandom % 60) == 0;
            tick(pg, en, oc);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule